// File: doc/BRIEF.md
# Interleaved Node Address Decoder

This block decides which of eight memory nodes owns a physical system address. It keeps eight address-window entries, each made of a lower-bound word and an upper-bound word, loaded through a plain single-cycle register-write port. A request carries a 64-bit address. The block decodes only the low 40 bits of that address. It returns the index of the owning entry, a hit flag and an error flag, all held in one output register.

Entry 0 picks the decode mode for the whole table. When its interleave-enable field is zero, the block works in window mode and searches the entries for one whose window holds the address. When the field is non-zero, the block works in interleaved mode. In that mode the address bits just above the 4 KiB page offset choose an entry through each entry's select field. The block then checks that the chosen entry's window really holds the address.

The request and result sides are valid/ready streams. A result waits in the output register until the consumer takes it. While a result is held and `rsp_ready` is low, `req_ready` stays low, so back-pressure reaches the producer in the same cycle. In every cycle where `rsp_ready` is high, one request can be accepted and one result can leave.

Top module: `node_addr_decoder`

## Requirements
- R1: After reset `rsp_valid` is 0, `req_ready` is 1, and every entry word is zero. Every entry is therefore unused, and any decode misses.
- R2: Address bits 63:40 have no effect on the result. Only bits 39:0 are decoded.
- R3: The lower-bound word holds address bits 39:24 in its bits 31:16. The upper-bound word uses the same layout, and its address bits 23:0 are taken as all ones. Both bounds are inclusive.
- R4: An entry whose lower-bound word has bits 1:0 equal to 00 is unused. It never matches in either mode.
- R5: In window mode (entry 0 lower-bound bits 10:8 equal to 0), the lowest-index used entry whose window holds the address wins. `rsp_node` is that index, `rsp_hit` is 1 and `rsp_err` is 0.
- R6: In interleaved mode, the only legal enable values are 1, 3 and 7. Any other non-zero value gives `rsp_err`=1, `rsp_hit`=0 and `rsp_node`=0.
- R7: In interleaved mode, the lowest-index used entry wins when its upper-bound bits 10:8 ANDed with the enable mask equal address bits 14:12 ANDed with the same mask.
- R8: In interleaved mode, if the winning entry's window does not hold the address, the result is `rsp_err`=1, `rsp_hit`=0 and `rsp_node`=0. `rsp_hit` and `rsp_err` are never 1 together.
- R9: When no entry matches and there is no error, the result is `rsp_hit`=0, `rsp_err`=0 and `rsp_node`=0.
- R10: A request accepted on an edge (`req_valid` and `req_ready` both high) gives `rsp_valid` after that edge. `req_ready` is equal to `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the result stays unchanged.
- R11: A write with `cfg_we`=1 stores `cfg_wdata` into entry `cfg_idx`. `cfg_lim`=0 selects the lower-bound word and `cfg_lim`=1 selects the upper-bound word. The write applies to requests accepted on later edges, but not to a request accepted on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Entry word write strobe |
| cfg_lim | input | 1 | 0 selects the lower-bound word, 1 selects the upper-bound word |
| cfg_idx | input | 3 | Entry index to write |
| cfg_wdata | input | 32 | Word to store |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 64 | System address to decode |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_node | output | 3 | Owning entry index, 0 when there is no hit |
| rsp_hit | output | 1 | Address owned by `rsp_node` |
| rsp_err | output | 1 | Illegal enable value, or interleave match outside the window |

## Verification
A wrong entry word or a wrong enable decode shows up on the result of the first request accepted after it. It appears on the very next cycle, as a wrong `rsp_node`, `rsp_hit` or `rsp_err`. Errors in the handshake state show up as a result that is dropped, duplicated or changed during a stall. These can be seen on `rsp_valid` or on `req_ready` in the cycle of the fault. A cycle-level reference model is therefore compared with the ports on every clock. The stimulus covers window boundaries, overlapping windows, unused entries, every class of interleave enable value and random back-pressure.

// File: rtl/node_dec_pkg.sv
package node_dec_pkg;
  localparam int WORD_W   = 32;
  localparam int BOUND_LSB = 16;
  localparam int BOUND_W  = WORD_W - BOUND_LSB;
  localparam int FLD_LSB  = 8;
  localparam int FLD_W    = 3;
  localparam int RW_W     = 2;
  localparam int PAGE_LSB = 12;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [FLD_W-1:0]  fld_t;

  typedef enum logic [1:0] {
    DEC_MISS = 2'd0,
    DEC_HIT  = 2'd1,
    DEC_ERR  = 2'd2
  } dec_kind_e;

  function automatic logic mask_legal(input fld_t en);
    return (en == 3'd1) || (en == 3'd3) || (en == 3'd7);
  endfunction
endpackage

// File: rtl/node_dec_regs.sv
module node_dec_regs
  import node_dec_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             lim_sel,
  input  logic [IDX_W-1:0] idx,
  input  word_t            wdata,
  output word_t            lo_q [ENTRIES],
  output word_t            hi_q [ENTRIES]
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[e] <= '0;
        hi_q[e] <= '0;
      end else if (we && (idx == IDX_W'(e))) begin
        if (lim_sel) hi_q[e] <= wdata;
        else         lo_q[e] <= wdata;
      end
    end
  end
endmodule

// File: rtl/node_dec_match.sv
module node_dec_match
  import node_dec_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PA_W    = 40
) (
  input  logic [PA_W-1:0] addr,
  input  fld_t            en_mask,
  input  word_t           lo_q [ENTRIES],
  input  word_t           hi_q [ENTRIES],
  output logic [ENTRIES-1:0] in_win,
  output logic [ENTRIES-1:0] sel_eq
);
  localparam int FILL_W = PA_W - BOUND_W;

  fld_t addr_sel;
  assign addr_sel = addr[PAGE_LSB +: FLD_W] & en_mask;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic            used;
    logic [PA_W-1:0] lo_a;
    logic [PA_W-1:0] hi_a;
    fld_t            ent_sel;
    assign used    = |lo_q[e][RW_W-1:0];
    assign lo_a    = {lo_q[e][WORD_W-1:BOUND_LSB], {FILL_W{1'b0}}};
    assign hi_a    = {hi_q[e][WORD_W-1:BOUND_LSB], {FILL_W{1'b1}}};
    assign ent_sel = hi_q[e][FLD_LSB +: FLD_W] & en_mask;
    assign in_win[e] = used && (addr >= lo_a) && (addr <= hi_a);
    assign sel_eq[e] = used && (ent_sel == addr_sel);
  end
endmodule

// File: rtl/node_dec_pick.sv
module node_dec_pick #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] req,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/node_addr_decoder.sv
module node_addr_decoder
  import node_dec_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 64,
  parameter int PA_W    = 40,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_lim,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [31:0]      cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [IDX_W-1:0] rsp_node,
  output logic             rsp_hit,
  output logic             rsp_err
);
  word_t lo_q [ENTRIES];
  word_t hi_q [ENTRIES];

  node_dec_regs #(.ENTRIES(ENTRIES)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .lim_sel(cfg_lim),
    .idx(cfg_idx), .wdata(cfg_wdata), .lo_q(lo_q), .hi_q(hi_q)
  );

  fld_t en_mask;
  logic ilv_on;
  assign en_mask = lo_q[0][FLD_LSB +: FLD_W];
  assign ilv_on  = |en_mask;

  logic [PA_W-1:0]    addr_pa;
  logic [ENTRIES-1:0] in_win;
  logic [ENTRIES-1:0] sel_eq;
  assign addr_pa = req_addr[PA_W-1:0];

  node_dec_match #(.ENTRIES(ENTRIES), .PA_W(PA_W)) u_match (
    .addr(addr_pa), .en_mask(en_mask), .lo_q(lo_q), .hi_q(hi_q),
    .in_win(in_win), .sel_eq(sel_eq)
  );

  logic             win_found, sel_found;
  logic [IDX_W-1:0] win_idx, sel_idx;

  node_dec_pick #(.ENTRIES(ENTRIES)) u_pick_win (
    .req(in_win), .found(win_found), .idx(win_idx)
  );
  node_dec_pick #(.ENTRIES(ENTRIES)) u_pick_sel (
    .req(sel_eq), .found(sel_found), .idx(sel_idx)
  );

  dec_kind_e        kind;
  logic [IDX_W-1:0] node_d;

  always_comb begin
    kind   = DEC_MISS;
    node_d = '0;
    if (!ilv_on) begin
      if (win_found) begin
        kind   = DEC_HIT;
        node_d = win_idx;
      end
    end else if (!mask_legal(en_mask)) begin
      kind = DEC_ERR;
    end else if (sel_found) begin
      if (in_win[sel_idx]) begin
        kind   = DEC_HIT;
        node_d = sel_idx;
      end else begin
        kind = DEC_ERR;
      end
    end
  end

  logic take;
  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_node  <= '0;
      rsp_hit   <= 1'b0;
      rsp_err   <= 1'b0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_node  <= node_d;
      rsp_hit   <= (kind == DEC_HIT);
      rsp_err   <= (kind == DEC_ERR);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/node_addr_decoder_chk.sv
module node_addr_decoder_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [IDX_W-1:0] rsp_node,
  input logic             rsp_hit,
  input logic             rsp_err
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_node) && $stable(rsp_hit) && $stable(rsp_err));
  // R10
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
  // R10
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);
  // R10
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && !req_valid |=> !rsp_valid);
  // R8
  hit_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_err));
  // R9
  miss_node_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_node == '0);
endmodule

bind node_addr_decoder node_addr_decoder_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_node(rsp_node),
  .rsp_hit(rsp_hit), .rsp_err(rsp_err)
);

// File: tb/node_addr_decoder_tb_top.sv
`timescale 1ns/1ps
module node_addr_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_lim = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [2:0]  rsp_node;
  logic        rsp_hit;
  logic        rsp_err;

  always #2.5 clk = ~clk;

  node_addr_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lim(cfg_lim),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_node(rsp_node), .rsp_hit(rsp_hit),
    .rsp_err(rsp_err)
  );

  int    total = 0;
  int    bad = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [31:0] m_lo [8];
  logic [31:0] m_hi [8];
  logic        m_valid = 1'b0;
  int          m_node = 0;
  logic        m_hit = 1'b0;
  logic        m_err = 1'b0;

  task automatic ref_decode(input logic [63:0] a, output int node,
                            output logic hit, output logic err);
    longint unsigned pa, lo, hi;
    int en, pick;
    pa = a & 64'hFF_FFFF_FFFF;
    node = 0; hit = 0; err = 0; pick = -1;
    en = int'(m_lo[0][10:8]);
    if (en == 0) begin
      for (int i = 0; i < 8; i++) begin
        lo = longint'(m_lo[i][31:16]) * 64'h100_0000;
        hi = longint'(m_hi[i][31:16]) * 64'h100_0000 + 64'hFF_FFFF;
        if (pick < 0 && m_lo[i][1:0] != 0 && pa >= lo && pa <= hi) pick = i;
      end
      if (pick >= 0) begin hit = 1; node = pick; end
    end else if (en != 1 && en != 3 && en != 7) begin
      err = 1;
    end else begin
      for (int i = 0; i < 8; i++)
        if (pick < 0 && m_lo[i][1:0] != 0 &&
            ((int'(m_hi[i][10:8]) & en) == (int'((pa >> 12) % 8) & en))) pick = i;
      if (pick >= 0) begin
        lo = longint'(m_lo[pick][31:16]) * 64'h100_0000;
        hi = longint'(m_hi[pick][31:16]) * 64'h100_0000 + 64'hFF_FFFF;
        if (pa >= lo && pa <= hi) begin hit = 1; node = pick; end
        else err = 1;
      end
    end
  endtask

  always @(posedge clk) begin
    int n; logic h, e;
    if (!rst_n) begin
      m_valid = 0; m_node = 0; m_hit = 0; m_err = 0;
      for (int i = 0; i < 8; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    end else begin
      if (req_valid && (!m_valid || rsp_ready)) begin
        ref_decode(req_addr, n, h, e);
        m_valid = 1; m_node = n; m_hit = h; m_err = e;
      end else if (rsp_ready) begin
        m_valid = 0;
      end
      if (cfg_we) begin
        if (cfg_lim) m_hi[cfg_idx] = cfg_wdata;
        else         m_lo[cfg_idx] = cfg_wdata;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    check(cur_req, "rsp_valid", int'(rsp_valid), int'(m_valid));
    check("R10", "req_ready", int'(req_ready), int'(!m_valid || rsp_ready));
    if (m_valid) begin
      check(cur_req, "rsp_node", int'(rsp_node), m_node);
      check(cur_req, "rsp_hit", int'(rsp_hit), int'(m_hit));
      check(cur_req, "rsp_err", int'(rsp_err), int'(m_err));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  function automatic logic [31:0] lo_word(input logic [15:0] top, input logic [2:0] en,
                                           input logic [1:0] rw);
    return {top, 5'd0, en, 6'd0, rw};
  endfunction
  function automatic logic [31:0] hi_word(input logic [15:0] top, input logic [2:0] sel);
    return {top, 5'd0, sel, 5'd0, 3'd0};
  endfunction

  task automatic wr(input int idx, input logic lim, input logic [31:0] d);
    cfg_we = 1; cfg_lim = lim; cfg_idx = 3'(idx); cfg_wdata = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic send(input logic [63:0] a);
    logic acc;
    req_valid = 1; req_addr = a;
    do begin
      acc = req_ready;
      tick();
    end while (!acc);
    req_valid = 0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 8; i++) begin wr(i, 0, '0); wr(i, 1, '0); end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state and empty table
    cur_req = "R1";
    check("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    check("R1", "req_ready after reset", int'(req_ready), 1);
    send(64'h0000_0000_0100_0000);
    tick();
    send(64'h0);
    tick();

    // R5/R3/R4: window mode table
    cur_req = "R11";
    wr(1, 0, lo_word(16'h0001, 3'd0, 2'b11));
    wr(1, 1, hi_word(16'h0001, 3'd0));
    wr(2, 0, lo_word(16'h0001, 3'd0, 2'b01));
    wr(2, 1, hi_word(16'h0003, 3'd0));
    wr(3, 0, lo_word(16'h0004, 3'd0, 2'b00));
    wr(3, 1, hi_word(16'h0005, 3'd0));
    wr(4, 0, lo_word(16'h0004, 3'd0, 2'b10));
    wr(4, 1, hi_word(16'h0005, 3'd0));
    cur_req = "R5";
    send(64'h0000_0000_0180_0000);   // overlap of 1 and 2 -> 1
    send(64'h0000_0000_0200_0000);   // only 2
    cur_req = "R3";
    send(64'h0000_0000_00FF_FFFF);   // just below entry 1
    send(64'h0000_0000_0100_0000);   // lower bound inclusive
    send(64'h0000_0000_03FF_FFFF);   // upper bound inclusive
    cur_req = "R4";
    send(64'h0000_0000_0400_0000);   // unused entry 3 skipped -> 4
    cur_req = "R9";
    send(64'h0000_0000_0600_0000);   // miss
    send(64'h0000_00FF_FFFF_FFFF);
    cur_req = "R2";
    send(64'hFFFF_FF00_0180_0000);
    send(64'hA5A5_A500_0400_0000);
    send(64'h1234_5600_0000_0000);

    // R11: write on the same edge as an accept uses the old table
    cur_req = "R11";
    req_valid = 1; req_addr = 64'h0000_0000_0600_0000;
    cfg_we = 1; cfg_lim = 1; cfg_idx = 3'd4; cfg_wdata = hi_word(16'h0007, 3'd0);
    tick();
    cfg_we = 0;
    tick();
    req_valid = 0;
    tick();

    // R10: stall
    cur_req = "R10";
    rsp_ready = 0;
    req_valid = 1; req_addr = 64'h0000_0000_0100_0000;
    tick();
    req_addr = 64'h0000_0000_0400_0000;
    repeat (4) tick();
    rsp_ready = 1;
    tick();
    req_valid = 0;
    repeat (2) tick();

    // interleaved mode
    clear_all();
    cur_req = "R11";
    wr(0, 0, lo_word(16'h0000, 3'd3, 2'b11));
    wr(0, 1, hi_word(16'h00FF, 3'd0));
    wr(1, 0, lo_word(16'h0000, 3'd0, 2'b11));
    wr(1, 1, hi_word(16'h00FF, 3'd1));
    wr(2, 0, lo_word(16'h0000, 3'd0, 2'b01));
    wr(2, 1, hi_word(16'h0000, 3'd2));
    wr(3, 0, lo_word(16'h0000, 3'd0, 2'b11));
    wr(3, 1, hi_word(16'h00FF, 3'd3));
    wr(5, 0, lo_word(16'h0000, 3'd0, 2'b11));
    wr(5, 1, hi_word(16'h00FF, 3'd6));
    cur_req = "R7";
    send(64'h0000_0000_0000_0000);
    send(64'h0000_0000_0000_1000);
    send(64'h0000_0000_0000_3000);
    send(64'h0000_0000_0000_5000);   // masked bits 01 -> entry 1
    send(64'h0000_0000_0000_2000);   // entry 2 in range
    cur_req = "R8";
    send(64'h0000_0000_0300_2000);   // entry 2 out of range
    send(64'h0000_0000_0500_6000);
    cur_req = "R7";
    wr(0, 0, lo_word(16'h0000, 3'd7, 2'b11));
    send(64'h0000_0000_0000_6000);   // full mask: 6 -> entry 5
    cur_req = "R9";
    send(64'h0000_0000_0000_5000);   // no select 5
    cur_req = "R6";
    wr(0, 0, lo_word(16'h0000, 3'd2, 2'b11));
    send(64'h0000_0000_0000_0000);
    wr(0, 0, lo_word(16'h0000, 3'd5, 2'b11));
    send(64'h0000_0000_0000_1000);
    wr(0, 0, lo_word(16'h0000, 3'd1, 2'b11));
    cur_req = "R7";
    send(64'h0000_0000_0000_3000);   // mask 1: bit12 -> entry 1
    send(64'h0000_0000_0000_6000);   // bit12 clear -> entry 0

    // random sweep in both modes with random back-pressure
    for (int pass = 0; pass < 2; pass++) begin
      cur_req = (pass == 0) ? "R7" : "R5";
      if (pass == 1) begin
        wr(0, 0, lo_word(16'h0002, 3'd0, 2'b11));
        wr(0, 1, hi_word(16'h0006, 3'd0));
      end
      for (int k = 0; k < 600; k++) begin
        req_valid = ($urandom % 4) != 0;
        rsp_ready = ($urandom % 3) != 0;
        if (req_ready || !req_valid)
          req_addr = {$urandom, $urandom} & (($urandom % 2) ? 64'hFFFF_FFFF_FFFF_FFFF
                                                            : 64'h0000_0000_0FFF_F000);
        tick();
      end
      req_valid = 0; rsp_ready = 1;
      repeat (2) tick();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule